// File: doc/BRIEF.md
# Receive Line Glitch Filter

This block cleans a serial receive line before a bit sampler reads it. The raw line first crosses into the system clock domain through a two-stage synchronizer. It then drives a 4-bit saturating up/down counter. The counter advances only on a filter-clock enable, which comes from a programmable prescaler. The cleaned output goes high only after the counter has sat at its top value for one more enabled step with the input high. It goes low only after the counter has sat at zero for one more enabled step with the input low.

A clean transition therefore reaches the output sixteen filter clocks after it leaves the synchronizer. Any pulse shorter than that is absorbed, because the counter turns round and heads back. The counter is never cleared between pulses, so closely spaced pulses add up. A one-cycle strobe marks every change of the cleaned output.

Top module: `rx_glitch_filter`

## Requirements
- R1: After reset the cleaned output is high, the edge strobe is low, and the filter counter holds its top value 0xF.
- R2: The raw line passes through two synchronizer flops before the counter sees it. With divide by 1, an output change therefore follows a clean raw transition by exactly 18 clock edges.
- R3: On each enabled filter step the counter moves by one toward the synchronized level. It saturates at 0x0 and at 0xF and never wraps.
- R4: The cleaned output rises only on an enabled step where the counter already holds 0xF and the synchronized level is high.
- R5: The cleaned output falls only on an enabled step where the counter already holds 0x0 and the synchronized level is low.
- R6: A clean transition reaches the output 16 enabled steps after the synchronized level changes. With divide by N, the output is unchanged 2+15N edges after the raw change and has changed by 2+16N edges.
- R7: `presc_sel` value 0, 1, 2 or 3 selects divide by 1, 2, 4 or 8. The filter step is a clock enable issued once every N system clocks.
- R8: An opposite-level pulse lasting fewer than 16 enabled steps leaves the output unchanged. With divide by 1, a 15-cycle pulse is rejected and a 16-cycle pulse passes, in both polarities.
- R9: The counter integrates across pulses. With divide by 1, low for 10 cycles, high for 3, then low for 10 drives the output low.
- R10: `rx_edge` is high for exactly the one cycle in which the cleaned output takes its new value, and low at all other times.
- R11: Between filter steps, neither the counter nor the cleaned output changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_raw | input | 1 | Unsynchronized receive line, idle high |
| presc_sel | input | 2 | Filter clock divide select: 0 for /1, 1 for /2, 2 for /4, 3 for /8 |
| rx_clean | output | 1 | Filtered receive line |
| rx_edge | output | 1 | One-cycle strobe on any change of rx_clean |

## Verification
Two events can fall on the same filter step: the counter reaching its end value, and the synchronized input turning back. Whichever wins decides whether a pulse survives. The bench provokes this coincidence with pulses of exactly 15 and 16 cycles at divide by 1, in both polarities. It judges the outcome by the final output level and by the count of output transitions and strobes. The reversal pattern of R9 repeats the contest mid-range, where the counter must resume from its partly integrated value instead of restarting.

// File: rtl/rgf_pkg.sv
// Package: shared constants and types for the receive glitch filter.
// Assumes a 4-bit filter counter and a 2-bit prescale select.
package rgf_pkg;
    localparam int CNT_W   = 4;
    localparam int SEL_W   = 2;
    localparam int SYNC_N  = 2;

    typedef logic [CNT_W-1:0] cnt_t;

    localparam cnt_t CNT_TOP = '1;
    localparam cnt_t CNT_BOT = '0;

    typedef enum logic [SEL_W-1:0] {
        DIV_1 = 2'd0,
        DIV_2 = 2'd1,
        DIV_4 = 2'd2,
        DIV_8 = 2'd3
    } presc_e;
endpackage

// File: rtl/rgf_sync.sv
// Module: multi-stage synchronizer for an asynchronous level.
// Assumes the input is a slowly changing level. The output is delayed by
// STAGES clocks and resets to RST_VAL.
module rgf_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] stage_q;

    generate
        for (genvar i = 0; i < STAGES; i++) begin : g_stage
            // Shift the level one flop further along the chain.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    stage_q[i] <= RST_VAL;
                else if (i == 0)
                    stage_q[i] <= d_async;
                else
                    stage_q[i] <= stage_q[(i > 0) ? i-1 : 0];
            end
        end
    endgenerate

    assign q_sync = stage_q[STAGES-1];
endmodule

// File: rtl/rgf_prescaler.sv
// Module: filter-clock enable generator.
// Issues a one-cycle enable every 2**sel system clocks. A select change
// takes effect at once. A count above the new limit simply fires and wraps.
module rgf_prescaler #(
    parameter int SEL_W = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [SEL_W-1:0] sel,
    output logic             tick
);
    localparam int MAX_DIV = 1 << ((1 << SEL_W) - 1);
    localparam int CW      = (MAX_DIV > 1) ? $clog2(MAX_DIV) : 1;

    logic [CW-1:0] div_q;
    logic [CW:0]   limit;

    // Derive the terminal count for the selected ratio.
    always_comb begin
        limit = ((CW+1)'(1) << sel) - (CW+1)'(1);
        tick  = ({1'b0, div_q} >= limit);
    end

    // Advance the divider, restarting after each enable.
    always_ff @(posedge clk) begin
        if (!rst_n)
            div_q <= '0;
        else if (tick)
            div_q <= '0;
        else
            div_q <= div_q + 1'b1;
    end
endmodule

// File: rtl/rgf_integrator.sv
// Module: saturating up/down integrator with end-value output toggling.
// Assumes a synchronized level and a one-cycle step enable. On each step
// the counter moves toward the level. The output flips one step after the
// counter has reached the matching end value.
module rgf_integrator #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step,
    input  logic             lvl,
    output logic [CNT_W-1:0] cnt,
    output logic             out_lvl,
    output logic             out_edge
);
    localparam logic [CNT_W-1:0] TOP = '1;
    localparam logic [CNT_W-1:0] BOT = '0;

    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic             out_q, out_d, edge_d, edge_q;

    // Next-state rule: count toward lvl, flip the output at a held end value.
    always_comb begin
        cnt_d  = cnt_q;
        out_d  = out_q;
        edge_d = 1'b0;
        if (step) begin
            if (lvl) begin
                if (cnt_q != TOP)
                    cnt_d = cnt_q + 1'b1;
                else if (!out_q) begin
                    out_d  = 1'b1;
                    edge_d = 1'b1;
                end
            end else begin
                if (cnt_q != BOT)
                    cnt_d = cnt_q - 1'b1;
                else if (out_q) begin
                    out_d  = 1'b0;
                    edge_d = 1'b1;
                end
            end
        end
    end

    // Register counter, output level and edge strobe; idle state is high.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q  <= TOP;
            out_q  <= 1'b1;
            edge_q <= 1'b0;
        end else begin
            cnt_q  <= cnt_d;
            out_q  <= out_d;
            edge_q <= edge_d;
        end
    end

    assign cnt      = cnt_q;
    assign out_lvl  = out_q;
    assign out_edge = edge_q;
endmodule

// File: rtl/rx_glitch_filter.sv
// Module: receive line glitch filter top.
// Chains the synchronizer, the prescaler and the integrator. Assumes
// rx_raw idles high and presc_sel is quasi-static.
module rx_glitch_filter
    import rgf_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_raw,
    input  logic [SEL_W-1:0] presc_sel,
    output logic             rx_clean,
    output logic             rx_edge
);
    logic sync_lvl;
    logic filt_tick;
    cnt_t filt_cnt;

    rgf_sync #(.STAGES(SYNC_N), .RST_VAL(1'b1)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (rx_raw),
        .q_sync  (sync_lvl)
    );

    rgf_prescaler #(.SEL_W(SEL_W)) u_presc (
        .clk   (clk),
        .rst_n (rst_n),
        .sel   (presc_sel),
        .tick  (filt_tick)
    );

    rgf_integrator #(.CNT_W(CNT_W)) u_integ (
        .clk      (clk),
        .rst_n    (rst_n),
        .step     (filt_tick),
        .lvl      (sync_lvl),
        .cnt      (filt_cnt),
        .out_lvl  (rx_clean),
        .out_edge (rx_edge)
    );
endmodule

// File: rtl/rgf_chk.sv
// Module: property checker for the glitch filter, attached by bind.
// Assumes the bound top exposes sync_lvl, filt_tick and filt_cnt.
module rgf_chk #(
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             rx_clean,
    input logic             rx_edge,
    input logic             sync_lvl,
    input logic             tick,
    input logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] TOP = '1;

    // R1
    reset_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (cnt == TOP && rx_clean && !rx_edge));

    // R3
    step_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(cnt) - int'($past(cnt)) <= 1) && (int'($past(cnt)) - int'(cnt) <= 1));

    // R4
    rise_at_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rx_clean) |-> ($past(cnt) == TOP && $past(sync_lvl) && $past(tick)));

    // R5
    fall_at_bot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rx_clean) |-> ($past(cnt) == '0 && !$past(sync_lvl) && $past(tick)));

    // R10
    edge_strobe_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_edge == (rx_clean != $past(rx_clean)));

    // R11
    hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !tick |=> ($stable(cnt) && $stable(rx_clean)));
endmodule

bind rx_glitch_filter rgf_chk #(.CNT_W(rgf_pkg::CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .rx_clean (rx_clean),
    .rx_edge  (rx_edge),
    .sync_lvl (sync_lvl),
    .tick     (filt_tick),
    .cnt      (filt_cnt)
);

// File: tb/rx_glitch_filter_tb.sv
module rx_glitch_filter_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_raw = 1'b1;
    logic [1:0] presc_sel = 2'd0;
    logic       rx_clean, rx_edge;

    int n_chk = 0;
    int n_err = 0;
    int n_trans = 0;
    int n_edge = 0;
    int n_dbl = 0;
    logic prev_out = 1'b1;
    logic prev_edge = 1'b0;
    bit   done = 0;

    always #10 clk = ~clk;   // 50 MHz

    rx_glitch_filter dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .rx_raw    (rx_raw),
        .presc_sel (presc_sel),
        .rx_clean  (rx_clean),
        .rx_edge   (rx_edge)
    );

    // Output monitor: counts transitions, strobes and double-wide strobes.
    always @(negedge clk) begin
        if (rst_n) begin
            if (rx_clean != prev_out) n_trans++;
            if (rx_edge) n_edge++;
            if (rx_edge && prev_edge) n_dbl++;
        end
        prev_out  = rx_clean;
        prev_edge = rx_edge;
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_err++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_mon();
        n_trans = 0; n_edge = 0; n_dbl = 0;
    endtask

    // Vector: {presc_sel, low pulse length, 1 if the pulse must pass}
    localparam logic [10:0] VEC [0:7] = '{
        {2'd0, 8'd15,  1'b0},
        {2'd0, 8'd16,  1'b1},
        {2'd1, 8'd20,  1'b0},
        {2'd1, 8'd40,  1'b1},
        {2'd2, 8'd50,  1'b0},
        {2'd2, 8'd80,  1'b1},
        {2'd3, 8'd100, 1'b0},
        {2'd3, 8'd160, 1'b1}
    };

    initial begin
        wait_n(3);
        // R1: reset state
        chk(rx_clean == 1'b1, "R1 reset output", rx_clean, 1);
        chk(rx_edge == 1'b0, "R1 reset strobe", rx_edge, 0);
        rst_n = 1'b1;
        wait_n(5);
        chk(rx_clean == 1'b1 && n_trans == 0, "R1 idle after reset", n_trans, 0);

        // R7 R8 R10: vector walk, low pulses at each divide ratio
        for (int v = 0; v < 8; v++) begin
            presc_sel = VEC[v][10:9];
            wait_n(20);
            clear_mon();
            rx_raw = 1'b0;
            wait_n(int'(VEC[v][8:1]));
            rx_raw = 1'b1;
            wait_n(250);
            chk(n_trans == (VEC[v][0] ? 2 : 0), $sformatf("R8 R7 vec%0d transitions", v),
                n_trans, VEC[v][0] ? 2 : 0);
            chk(n_edge == n_trans && n_dbl == 0, $sformatf("R10 vec%0d strobes", v),
                n_edge, n_trans);
            chk(rx_clean == 1'b1, $sformatf("R8 vec%0d final level", v), rx_clean, 1);
        end

        // R2 R6: exact latency at divide by 1
        presc_sel = 2'd0;
        wait_n(20);
        rx_raw = 1'b0;
        wait_n(17);
        chk(rx_clean == 1'b1, "R2 no change at 17 edges", rx_clean, 1);
        wait_n(1);
        chk(rx_clean == 1'b0, "R2 change at 18 edges", rx_clean, 0);

        // R8 R4: high glitches while settled low, 15 rejected, 16 passes
        wait_n(40);
        clear_mon();
        rx_raw = 1'b1; wait_n(15); rx_raw = 1'b0; wait_n(60);
        chk(rx_clean == 1'b0 && n_trans == 0, "R8 high 15 rejected", n_trans, 0);
        clear_mon();
        rx_raw = 1'b1; wait_n(16); rx_raw = 1'b0; wait_n(60);
        chk(n_trans == 2 && n_edge == 2, "R4 high 16 passes", n_trans, 2);

        // R6 R5: bounds at divide by 8 for a rising edge
        presc_sel = 2'd3;
        wait_n(200);
        rx_raw = 1'b1;
        wait_n(2 + 15*8);
        chk(rx_clean == 1'b0, "R6 div8 not before 2+15N", rx_clean, 0);
        wait_n(8);
        chk(rx_clean == 1'b1, "R6 div8 by 2+16N", rx_clean, 1);

        // R9 R3: integration across a reversal at divide by 1
        presc_sel = 2'd0;
        wait_n(40);
        clear_mon();
        rx_raw = 1'b0; wait_n(10);
        rx_raw = 1'b1; wait_n(3);
        rx_raw = 1'b0; wait_n(10);
        wait_n(5);
        chk(rx_clean == 1'b0 && n_trans == 1, "R9 reversal integrates", n_trans, 1);
        // R3: from zero, 16 high steps are needed, proving saturation at 0
        rx_raw = 1'b1;
        wait_n(17);
        chk(rx_clean == 1'b0, "R3 saturated low holds", rx_clean, 0);
        wait_n(1);
        chk(rx_clean == 1'b1, "R3 rises after 16 steps", rx_clean, 1);

        done = 1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (150000) @(posedge clk);
                chk(1'b0, "watchdog expired", 0, 1);
            end
        join_any
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end
endmodule